// File: doc/BRIEF.md
# Cascadable Up/Down Binary Counter

This block is a synchronous binary counter, four bits wide by default, that counts up or down on each rising clock edge. Each bit is a toggle flip-flop. A bit toggles when every lower bit is 1 while counting up, or when every lower bit is 0 while counting down. A single active-low enable gates all counting. The same enable is what links one stage to the next.

A preset input loads the whole count at once from a data bus, with no clock edge needed. While the preset is held, it takes priority over counting. An active-low carry-out marks the terminal count in the current direction. To build a wider counter, wire one stage's carry-out to the next stage's carry-in, with all stages on the same clock. The carry then ripples through the combinational terminal-count logic of every stage within one cycle.

Top module: `udc_counter`

## Requirements
- R1: While rst_ni is low and preset_en_i is low, count_o is 0, whatever the clock is doing.
- R2: With carry_n_i low, preset_en_i low and up_i = 1, count_o rises by one on each rising clock edge, and 15 wraps to 0.
- R3: With carry_n_i low, preset_en_i low and up_i = 0, count_o falls by one on each rising clock edge, and 0 wraps to 15.
- R4: With carry_n_i high and preset_en_i low, count_o is unchanged across a clock edge in either direction.
- R5: When up_i = 1, carry_n_o is low exactly when carry_n_i is low and count_o is 15. It is never low while carry_n_i is high.
- R6: When up_i = 0, carry_n_o is low exactly when carry_n_i is low and count_o is 0.
- R7: Raising preset_en_i between clock edges makes count_o equal preset_i at once, with no clock edge.
- R8: While preset_en_i stays high across clock edges, count_o keeps showing preset_i. After preset_en_i falls, the first rising edge counts on from the preset value.
- R9: Two stages, with the high stage's carry_n_i tied to the low stage's carry_n_o, form an 8-bit counter. The upper nibble steps on the same edge on which the lower nibble wraps.
- R10: A change of up_i between edges sets the direction of the very next counting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low, clears the count |
| up_i | input | 1 | Direction: 1 counts up, 0 counts down |
| preset_en_i | input | 1 | Asynchronous parallel load, active high |
| preset_i | input | WIDTH | Value to load |
| carry_n_i | input | 1 | Count enable / cascade input, active low |
| count_o | output | WIDTH | Current count |
| carry_n_o | output | 1 | Terminal count in the current direction, gated by carry_n_i, active low |

## Verification
The bench chains two stages and drives them through both wrap points, from 0xFF to 0x00 going up and from 0x00 to 0xFF going down. A wrong toggle term or a broken carry path shows up here as a nibble that skips or fails to step. A design with a clock-synchronous preset is caught because the bench raises preset mid-cycle and checks the count before any edge. A design that drops a preset held across an edge, or that loses the first count after release, is also caught. The bench checks holding with carry-in inactive at the carry-out pin as well as at the count, because a carry-out left ungated by the enable would make a downstream stage count wrongly.

// File: rtl/udc_pkg.sv
package udc_pkg;
  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } udc_dir_e;
endpackage

// File: rtl/udc_toggle_gen.sv
module udc_toggle_gen
  import udc_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] q_i,
  input  logic             up_i,
  input  logic             en_i,
  output logic [WIDTH-1:0] tog_o,
  output logic             term_o
);
  udc_dir_e dir;
  assign dir = udc_dir_e'(up_i);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    if (i == 0) begin : g_lsb
      assign tog_o[i] = en_i;
    end else begin : g_upper
      logic all_one, all_zero;
      assign all_one  = &q_i[i-1:0];
      assign all_zero = ~|q_i[i-1:0];
      assign tog_o[i] = en_i & ((dir == DIR_UP) ? all_one : all_zero);
    end
  end

  // terminal count in the active direction
  assign term_o = (dir == DIR_UP) ? &q_i : ~|q_i;
endmodule

// File: rtl/udc_tff.sv
module udc_tff (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic load_d_i,
  input  logic tog_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni or posedge load_i) begin
    if (!rst_ni)     q_o <= 1'b0;
    else if (load_i) q_o <= load_d_i;
    else if (tog_i)  q_o <= ~q_o;
  end
endmodule

// File: rtl/udc_counter.sv
module udc_counter #(
  parameter int WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             up_i,
  input  logic             preset_en_i,
  input  logic [WIDTH-1:0] preset_i,
  input  logic             carry_n_i,
  output logic [WIDTH-1:0] count_o,
  output logic             carry_n_o
);
  logic [WIDTH-1:0] q;
  logic [WIDTH-1:0] tog;
  logic             cnt_en;
  logic             term;

  assign cnt_en = ~carry_n_i;

  udc_toggle_gen #(.WIDTH(WIDTH)) u_tog (
    .q_i    (q),
    .up_i   (up_i),
    .en_i   (cnt_en),
    .tog_o  (tog),
    .term_o (term)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_ff
    udc_tff u_ff (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .load_i   (preset_en_i),
      .load_d_i (preset_i[i]),
      .tog_i    (tog[i]),
      .q_o      (q[i])
    );
  end

  // preset data shows through while the load is held
  assign count_o   = preset_en_i ? preset_i : q;
  assign carry_n_o = ~(cnt_en & term);
endmodule

// File: rtl/udc_counter_chk.sv
module udc_counter_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             up_i,
  input logic             preset_en_i,
  input logic [WIDTH-1:0] preset_i,
  input logic             carry_n_i,
  input logic [WIDTH-1:0] count_o,
  input logic             carry_n_o
);
  localparam logic [WIDTH-1:0] MAXV = {WIDTH{1'b1}};

  assert_reset_R1: assert property (@(posedge clk_i)
    (!rst_ni && !preset_en_i) |-> count_o == '0);

  assert_up_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!carry_n_i && up_i && !preset_en_i) |=>
      (preset_en_i || count_o == WIDTH'($past(count_o) + 1'b1)));

  assert_down_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!carry_n_i && !up_i && !preset_en_i) |=>
      (preset_en_i || count_o == WIDTH'($past(count_o) - 1'b1)));

  assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (carry_n_i && !preset_en_i) |=> (preset_en_i || $stable(count_o)));

  assert_carry_gated_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !carry_n_o |-> !carry_n_i);

  assert_carry_wrap_up_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!carry_n_o && up_i && !preset_en_i) |=> (preset_en_i || count_o == '0));

  assert_carry_wrap_dn_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!carry_n_o && !up_i && !preset_en_i) |=> (preset_en_i || count_o == MAXV));

  assert_preset_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    preset_en_i |-> count_o == preset_i);
endmodule

bind udc_counter udc_counter_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .up_i        (up_i),
  .preset_en_i (preset_en_i),
  .preset_i    (preset_i),
  .carry_n_i   (carry_n_i),
  .count_o     (count_o),
  .carry_n_o   (carry_n_o)
);

// File: tb/tb_udc_counter.sv
module tb_udc_counter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       up = 1'b1;
  logic       pe = 1'b0;
  logic [7:0] pdata = '0;
  logic       cin_n = 1'b1;
  logic [3:0] cnt_lo, cnt_hi;
  logic       co_lo, co_hi;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] ref_cnt = '0;

  always #5 clk = ~clk;

  udc_counter #(.WIDTH(4)) dut (
    .clk_i(clk), .rst_ni(rst_n), .up_i(up), .preset_en_i(pe),
    .preset_i(pdata[3:0]), .carry_n_i(cin_n), .count_o(cnt_lo), .carry_n_o(co_lo)
  );
  udc_counter #(.WIDTH(4)) dut_hi (
    .clk_i(clk), .rst_ni(rst_n), .up_i(up), .preset_en_i(pe),
    .preset_i(pdata[7:4]), .carry_n_i(co_lo), .count_o(cnt_hi), .carry_n_o(co_hi)
  );

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic ref_co();
    return !(!cin_n && (up ? ref_cnt == 8'hFF : ref_cnt == 8'h00));
  endfunction

  task automatic check_all(input string req);
    check(req, {1'b0, cnt_hi, cnt_lo}, {1'b0, ref_cnt});
    check(req, {8'h00, co_hi}, {8'h00, ref_co()});
  endtask

  // one rising edge, reference updated from inputs held across it
  task automatic tick();
    @(posedge clk);
    if (!rst_n) ref_cnt = '0;
    else if (pe) ref_cnt = pdata;
    else if (!cin_n) ref_cnt = up ? ref_cnt + 8'd1 : ref_cnt - 8'd1;
    #2;
  endtask

  task automatic load(input logic [7:0] v);
    pdata = v; pe = 1'b1; #1; ref_cnt = v;
    tick(); pe = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; cin_n = 1'b0;
    tick(); tick();
    check_all("R1");
    rst_n = 1'b1; cin_n = 1'b1;
    tick();
    check_all("R1");
  endtask

  task automatic t_up_wrap();
    up = 1'b1; load(8'hFC); cin_n = 1'b0;
    for (int i = 0; i < 6; i++) begin
      check_all("R2");
      tick();
    end
    check_all("R9");
    load(8'h0E);
    for (int i = 0; i < 3; i++) begin
      tick();
      check_all("R9");
    end
  endtask

  task automatic t_down_wrap();
    up = 1'b0; load(8'h03); cin_n = 1'b0;
    for (int i = 0; i < 6; i++) begin
      check_all("R3");
      tick();
    end
    check_all("R3");
  endtask

  task automatic t_hold();
    load(8'h5A); cin_n = 1'b1;
    for (int i = 0; i < 3; i++) begin
      up = i[0];
      tick();
      check_all("R4");
    end
    load(8'hFF); up = 1'b1; cin_n = 1'b1; #1;
    check("R5", {8'h00, co_hi}, 9'h001);
    check("R5", {8'h00, co_lo}, 9'h001);
  endtask

  task automatic t_carry();
    load(8'hFF); up = 1'b1; cin_n = 1'b0; #1;
    check("R5", {8'h00, co_hi}, 9'h000);
    check("R5", {8'h00, co_lo}, 9'h000);
    load(8'hFE); #1;
    check("R5", {8'h00, co_hi}, 9'h001);
    load(8'h00); up = 1'b0; #1;
    check("R6", {8'h00, co_hi}, 9'h000);
    check("R6", {8'h00, co_lo}, 9'h000);
    load(8'h10); #1;
    check("R6", {8'h00, co_hi}, 9'h001);
    check("R6", {8'h00, co_lo}, 9'h000);
    tick();
    check_all("R9");
  endtask

  task automatic t_async_preset();
    up = 1'b1; cin_n = 1'b0;
    tick();
    #1; pdata = 8'hA5; pe = 1'b1; ref_cnt = 8'hA5; #1;
    check("R7", {1'b0, cnt_hi, cnt_lo}, 9'h0A5);
    tick(); check_all("R8");
    tick(); check_all("R8");
    @(negedge clk); pe = 1'b0;
    tick(); check_all("R8");
    check("R8", {1'b0, cnt_hi, cnt_lo}, 9'h0A6);
  endtask

  task automatic t_dir_change();
    load(8'h40); cin_n = 1'b0; up = 1'b0;
    tick(); check_all("R10");
    up = 1'b1;
    tick(); check_all("R10");
    tick(); check_all("R10");
    check("R10", {1'b0, cnt_hi, cnt_lo}, 9'h041);
  endtask

  initial begin
    #100000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #3;
    check("R1", {1'b0, cnt_hi, cnt_lo}, 9'h000);
    t_reset();
    t_up_wrap();
    t_down_wrap();
    t_hold();
    t_carry();
    t_async_preset();
    t_dir_change();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule